// File: doc/BRIEF.md
# Interleaved DRAM Range Node Router

This block decides which node of a multi-node system owns a given 40-bit physical DRAM address. It holds eight programmable address windows. Each window has a lower bound and an upper bound on address bits 39:24, separate permissions for reads and writes, an optional node-interleave rule on address bits 14:12, and the ID of the destination node. A request gives an address and its type (read or write). One clock later the block returns whether a window claimed the request and, if one did, the node ID from that window.

Software programs the windows through a plain write port. The port selects a window index and chooses between its bound-low word and its bound-high word. The permission bits sit in the bound-low word. Software should therefore write the bound-high word first and enable the window last. A request sampled on the same edge as a configuration write still sees the old contents. Interleaving splits one address range across two, four or eight nodes. Each node receives its own copy of the window, differing only in the select value that the low address bits must match.

Top module: `dram_node_router`

## Requirements
- R1: While reset is held, and in any cycle whose response is not valid, rsp_valid, rsp_hit and rsp_miss are 0 and rsp_node is 0. After reset every window is disabled.
- R2: A window matches only when its lower bound (bound-low word bits 31:16) is less than or equal to req_addr[39:24], and req_addr[39:24] is less than or equal to its upper bound (bound-high word bits 31:16). Both ends are inclusive.
- R3: A read (req_write=0) can match a window only if bit 0 of that window's bound-low word is 1.
- R4: A write (req_write=1) can match a window only if bit 1 of that window's bound-low word is 1.
- R5: Interleave code 001 in bound-low bits 10:8 makes the window match only when req_addr[12] equals bit 8 of the bound-high word.
- R6: Interleave code 011 makes the window match only when req_addr[13:12] equals bound-high bits 9:8. Bound-high bit 10 and req_addr[14] are ignored.
- R7: Interleave code 111 makes the window match only when req_addr[14:12] equals bound-high bits 10:8.
- R8: Interleave codes 000, 010, 100, 101 and 110 apply no interleave check, so req_addr[14:12] has no effect on the match.
- R9: When several windows match, the one with the lowest index wins.
- R10: A valid request that matches no window gives rsp_miss=1, rsp_hit=0 and rsp_node=0. A valid request never sets both rsp_hit and rsp_miss.
- R11: On a match, rsp_node carries bits 2:0 of the winning window's bound-high word.
- R12: The response appears exactly one clock after the request edge. A configuration write takes effect for requests sampled on the following edges, not for a request sampled on the same edge.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_limit | input | 1 | 1 selects the bound-high word, 0 selects the bound-low word |
| cfg_idx | input | 3 | Window index to write |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 40 | Physical address |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A window claimed the request |
| rsp_miss | output | 1 | No window claimed the request |
| rsp_node | output | 3 | Destination node ID on a hit, 0 otherwise |

## Verification
The hardest case to reach is a set of overlapping windows that differ only in permission or interleave select. In that case the winner depends on the request type and on address bits 14:12 together with the index priority. The stimulus stacks windows over the same range on purpose. It then sweeps the interleave bits and alternates reads and writes, so that lower-index windows are skipped for permission and select reasons. Random address and request traffic, with configuration rewrites mixed in, also places writes on the same edge as requests. This exercises the old-value rule, and the behavioural model checks every cycle.

// File: rtl/dram_route_pkg.sv
package dram_route_pkg;

   // Field positions inside a configuration word
   localparam int RD_EN_BIT = 0;
   localparam int WR_EN_BIT = 1;
   localparam int ILV_LSB   = 8;
   localparam int ILV_W     = 3;
   localparam int NODE_LSB  = 0;

   // Turns an interleave code into the mask of compared address bits.
   // Reserved codes fall back to no interleave.
   function automatic logic [ILV_W-1:0] ilv_mask(input logic [ILV_W-1:0] code);
      logic [ILV_W-1:0] m;
      case (code)
         3'b001:  m = 3'b001;
         3'b011:  m = 3'b011;
         3'b111:  m = 3'b111;
         default: m = 3'b000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/dram_range_regs.sv
module dram_range_regs
   import dram_route_pkg::*;
#(
   parameter int NUM     = 8,
   parameter int DATA_W  = 32,
   parameter int RANGE_W = 16,
   parameter int NODE_W  = 3,
   localparam int IDX_W  = $clog2(NUM)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic                           wr_limit,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [NUM-1:0][RANGE_W-1:0]    lo_bound,
   output logic [NUM-1:0][RANGE_W-1:0]    hi_bound,
   output logic [NUM-1:0]                 rd_ok,
   output logic [NUM-1:0]                 wr_ok,
   output logic [NUM-1:0][ILV_W-1:0]      ilv_code,
   output logic [NUM-1:0][ILV_W-1:0]      ilv_sel,
   output logic [NUM-1:0][NODE_W-1:0]     node_id
);

   localparam int BOUND_LSB = DATA_W - RANGE_W;

   for (genvar r = 0; r < NUM; r++) begin : g_win
      logic [RANGE_W-1:0] lo_q, hi_q;
      logic               rd_q, wr_q;
      logic [ILV_W-1:0]   code_q, sel_q;
      logic [NODE_W-1:0]  node_q;
      logic               hit_idx;

      assign hit_idx = wr_en && (wr_idx == IDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q   <= '0;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            code_q <= '0;
         end else if (hit_idx && !wr_limit) begin
            lo_q   <= wr_data[BOUND_LSB +: RANGE_W];
            rd_q   <= wr_data[RD_EN_BIT];
            wr_q   <= wr_data[WR_EN_BIT];
            code_q <= wr_data[ILV_LSB +: ILV_W];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q   <= '0;
            sel_q  <= '0;
            node_q <= '0;
         end else if (hit_idx && wr_limit) begin
            hi_q   <= wr_data[BOUND_LSB +: RANGE_W];
            sel_q  <= wr_data[ILV_LSB +: ILV_W];
            node_q <= wr_data[NODE_LSB +: NODE_W];
         end
      end

      assign lo_bound[r] = lo_q;
      assign hi_bound[r] = hi_q;
      assign rd_ok[r]    = rd_q;
      assign wr_ok[r]    = wr_q;
      assign ilv_code[r] = code_q;
      assign ilv_sel[r]  = sel_q;
      assign node_id[r]  = node_q;
   end

endmodule

// File: rtl/dram_range_match.sv
module dram_range_match
   import dram_route_pkg::*;
#(
   parameter int RANGE_W = 16
) (
   input  logic [RANGE_W-1:0] upper,
   input  logic [ILV_W-1:0]   low_bits,
   input  logic               is_write,
   input  logic [RANGE_W-1:0] lo_bound,
   input  logic [RANGE_W-1:0] hi_bound,
   input  logic               rd_ok,
   input  logic               wr_ok,
   input  logic [ILV_W-1:0]   code,
   input  logic [ILV_W-1:0]   sel,
   output logic               hit
);

   logic in_range, perm, ilv_pass;
   logic [ILV_W-1:0] mask;

   always_comb begin
      mask     = ilv_mask(code);
      in_range = (upper >= lo_bound) && (upper <= hi_bound);
      perm     = is_write ? wr_ok : rd_ok;
      ilv_pass = ((low_bits ^ sel) & mask) == '0;
      hit      = in_range && perm && ilv_pass;
   end

endmodule

// File: rtl/dram_hit_pick.sv
module dram_hit_pick #(
   parameter int NUM    = 8,
   parameter int NODE_W = 3
) (
   input  logic [NUM-1:0]             hits,
   input  logic [NUM-1:0][NODE_W-1:0] nodes,
   output logic [NUM-1:0]             grant,
   output logic                       any,
   output logic [NODE_W-1:0]          node
);

   always_comb begin
      grant = '0;
      node  = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (hits[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            node     = nodes[i];
         end
      end
      any = |hits;
   end

endmodule

// File: rtl/dram_node_router.sv
module dram_node_router
   import dram_route_pkg::*;
#(
   parameter int NUM       = 8,
   parameter int ADDR_W    = 40,
   parameter int RANGE_LSB = 24,
   parameter int ILV_ALSB  = 12,
   parameter int DATA_W    = 32,
   parameter int NODE_W    = 3,
   parameter bit OUT_REG   = 1'b1,
   localparam int IDX_W    = $clog2(NUM),
   localparam int RANGE_W  = ADDR_W - RANGE_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_is_limit,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic [NODE_W-1:0] rsp_node
);

   // Elaboration checks on the parameter set
   if (NUM < 2) begin : g_bad_num
      $error("NUM must be at least 2");
   end
   if (RANGE_W > DATA_W - (ILV_LSB + ILV_W)) begin : g_bad_range
      $error("bound field overlaps the low control fields");
   end
   if (ILV_ALSB + ILV_W > RANGE_LSB) begin : g_bad_ilv
      $error("interleave bits must lie below the compared range");
   end
   if (NODE_W > ILV_LSB) begin : g_bad_node
      $error("node field overlaps the interleave select");
   end

   logic [NUM-1:0][RANGE_W-1:0] lo_bound, hi_bound;
   logic [NUM-1:0]              rd_ok, wr_ok;
   logic [NUM-1:0][ILV_W-1:0]   ilv_code, ilv_sel;
   logic [NUM-1:0][NODE_W-1:0]  node_id;
   logic [NUM-1:0]              hit_vec, grant;
   logic                        any_hit;
   logic [NODE_W-1:0]           win_node;
   logic [RANGE_W-1:0]          upper;
   logic [ILV_W-1:0]            low_bits;

   assign upper    = req_addr[RANGE_LSB +: RANGE_W];
   assign low_bits = req_addr[ILV_ALSB +: ILV_W];

   dram_range_regs #(
      .NUM(NUM), .DATA_W(DATA_W), .RANGE_W(RANGE_W), .NODE_W(NODE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_limit(cfg_is_limit), .wr_idx(cfg_idx), .wr_data(cfg_wdata),
      .lo_bound(lo_bound), .hi_bound(hi_bound), .rd_ok(rd_ok), .wr_ok(wr_ok),
      .ilv_code(ilv_code), .ilv_sel(ilv_sel), .node_id(node_id)
   );

   for (genvar r = 0; r < NUM; r++) begin : g_match
      dram_range_match #(.RANGE_W(RANGE_W)) u_match (
         .upper(upper), .low_bits(low_bits), .is_write(req_write),
         .lo_bound(lo_bound[r]), .hi_bound(hi_bound[r]),
         .rd_ok(rd_ok[r]), .wr_ok(wr_ok[r]),
         .code(ilv_code[r]), .sel(ilv_sel[r]), .hit(hit_vec[r])
      );

      // R3
      rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_write && !rd_ok[r]) |-> !hit_vec[r]);
      // R4
      wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_write && !wr_ok[r]) |-> !hit_vec[r]);
      // R2
      range_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (upper < lo_bound[r] || upper > hi_bound[r]) |-> !hit_vec[r]);
   end

   dram_hit_pick #(.NUM(NUM), .NODE_W(NODE_W)) u_pick (
      .hits(hit_vec), .nodes(node_id), .grant(grant), .any(any_hit), .node(win_node)
   );

   // R9
   one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~hit_vec) == '0));

   logic              nx_hit, nx_miss;
   logic [NODE_W-1:0] nx_node;

   always_comb begin
      nx_hit  = req_valid && any_hit;
      nx_miss = req_valid && !any_hit;
      nx_node = nx_hit ? win_node : '0;
   end

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_node  <= '0;
         end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= nx_hit;
            rsp_miss  <= nx_miss;
            rsp_node  <= nx_node;
         end
      end

      // R12
      latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);
   end else begin : g_comb_out
      assign rsp_valid = req_valid;
      assign rsp_hit   = nx_hit;
      assign rsp_miss  = nx_miss;
      assign rsp_node  = nx_node;
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_miss && rsp_node == '0));
   // R10
   hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit != rsp_miss));
   // R10
   miss_node_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_node == '0));

endmodule

// File: tb/dram_node_router_bench.sv
module dram_node_router_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_is_limit = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [39:0] req_addr = '0;
   logic        rsp_valid, rsp_hit, rsp_miss;
   logic [2:0]  rsp_node;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   string tag = "R1";

   logic [31:0] m_lo [8];
   logic [31:0] m_hi [8];

   always #2 clk = ~clk;

   dram_node_router u_dram_node_router (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_is_limit(cfg_is_limit), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_node(rsp_node)
   );

   function automatic void model(input bit v, input bit w, input logic [39:0] a,
                                 output logic [5:0] e);
      bit eh = 0;
      int en = 0;
      int u = int'(a[39:24]);
      if (v) begin
         for (int i = 0; i < 8; i++) begin
            int lo = int'(m_lo[i][31:16]);
            int hi = int'(m_hi[i][31:16]);
            bit ok = w ? m_lo[i][1] : m_lo[i][0];
            int nb, want, got;
            case (int'(m_lo[i][10:8]))
               1: nb = 1;
               3: nb = 2;
               7: nb = 3;
               default: nb = 0;
            endcase
            want = int'(m_hi[i][10:8]) % (1 << nb);
            got  = int'(a[14:12]) % (1 << nb);
            if (!eh && lo <= u && u <= hi && ok && want == got) begin
               eh = 1;
               en = int'(m_hi[i][2:0]);
            end
         end
      end
      e = {v, eh, v && !eh, 3'(en)};
   endfunction

   task automatic compare(input logic [5:0] e);
      logic [5:0] got = {rsp_valid, rsp_hit, rsp_miss, rsp_node};
      total++;
      if (got !== e) begin
         bad++;
         $display("FAIL %s: got v/h/m/node=%b/%b/%b/%0d exp %b/%b/%b/%0d",
                  tag, got[5], got[4], got[3], got[2:0], e[5], e[4], e[3], e[2:0]);
      end
   endtask

   // One clock: drive at the falling edge, predict, then compare at the next falling edge
   task automatic cyc(input bit we, input bit lim, input int idx, input logic [31:0] d,
                      input bit v, input bit w, input logic [39:0] a);
      logic [5:0] e;
      cfg_we = we; cfg_is_limit = lim; cfg_idx = 3'(idx); cfg_wdata = d;
      req_valid = v; req_write = w; req_addr = a;
      model(v, w, a, e);
      if (we) begin
         if (lim) m_hi[idx] = d; else m_lo[idx] = d;
      end
      @(negedge clk);
      compare(e);
   endtask

   task automatic wr_hi(input int idx, input int hi, input int sel, input int node);
      cyc(1, 1, idx, {16'(hi), 5'd0, 3'(sel), 5'd0, 3'(node)}, 0, 0, '0);
   endtask
   task automatic wr_lo(input int idx, input int lo, input int code, input bit wr, input bit rd);
      cyc(1, 0, idx, {16'(lo), 5'd0, 3'(code), 6'd0, wr, rd}, 0, 0, '0);
   endtask
   task automatic rq(input bit w, input int up, input int lowb);
      cyc(0, 0, 0, '0, 1, w, {16'(up), 9'd0, 3'(lowb), 12'h5a5});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got hang exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
      req_valid = 1'b1; req_addr = 40'h00_1234_5678;
      @(negedge clk); @(negedge clk);
      tag = "R1"; compare(6'b0);               // R1 outputs quiet during reset
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      tag = "R1"; rq(0, 0, 0); rq(1, 'h100, 3); cyc(0,0,0,'0,0,0,'0); // R1 all disabled: miss

      // R2 R3 R11: window 0 reads only, node 5
      tag = "R2";
      wr_hi(0, 'h003f, 0, 5); wr_lo(0, 'h0000, 0, 0, 1);
      rq(0, 'h0000, 0); rq(0, 'h003f, 7); rq(0, 'h0040, 0);
      tag = "R11"; rq(0, 'h0011, 2);
      tag = "R3"; rq(1, 'h0010, 0);
      // R4: window 1 writes only, node 2
      tag = "R4";
      wr_hi(1, 'h007f, 0, 2); wr_lo(1, 'h0040, 0, 1, 0);
      rq(1, 'h0050, 0); rq(0, 'h0050, 0); rq(1, 'h0080, 0);
      // R9: window 2 overlaps both, node 7
      tag = "R9";
      wr_hi(2, 'h00ff, 0, 7); wr_lo(2, 'h0000, 0, 1, 1);
      rq(0, 'h0010, 0); rq(1, 'h0010, 0); rq(1, 'h0060, 0); rq(0, 'h0060, 0); rq(0, 'h0080, 0);
      // R5: two-way split on A[12]
      tag = "R5";
      wr_hi(3, 'h01ff, 1, 1); wr_lo(3, 'h0100, 1, 1, 1);
      wr_hi(4, 'h01ff, 0, 4); wr_lo(4, 'h0100, 1, 1, 1);
      for (int b = 0; b < 8; b++) rq(b[0], 'h0150, b);
      // R6: four-way, select 6 compares only low two bits
      tag = "R6";
      wr_hi(5, 'h02ff, 6, 3); wr_lo(5, 'h0200, 3, 1, 1);
      for (int b = 0; b < 8; b++) rq(0, 'h0280, b);
      // R7: eight-way, select 5
      tag = "R7";
      wr_hi(6, 'h03ff, 5, 6); wr_lo(6, 'h0300, 7, 1, 1);
      for (int b = 0; b < 8; b++) rq(1, 'h0300, b);
      // R8: reserved codes behave as no interleave
      tag = "R8";
      wr_hi(7, 'h04ff, 3, 2);
      for (int c = 0; c < 8; c++) begin
         if (c == 1 || c == 3 || c == 7) continue;
         wr_lo(7, 'h0400, c, 1, 1);
         for (int b = 0; b < 8; b++) rq(0, 'h04ff, b);
      end
      // R12: write and request on the same edge
      tag = "R12";
      cyc(1, 0, 7, 32'h0400_0000, 1, 0, {16'h0400, 24'h0});
      rq(0, 'h0400, 0);
      cyc(1, 1, 0, 32'h003f_0001, 1, 0, {16'h0001, 24'h0});
      rq(0, 'h0001, 0);
      // R10 and all: random traffic with config rewrites
      tag = "R10";
      for (int n = 0; n < 1500; n++) begin
         bit we = ($urandom_range(0, 9) == 0);
         int ix = $urandom_range(0, 7);
         logic [31:0] d = $urandom;
         d[31:16] = 16'($urandom_range(0, 'h5ff));
         cyc(we, $urandom_range(0, 1) == 1, ix, d, $urandom_range(0, 3) != 0,
             $urandom_range(0, 1) == 1, {16'($urandom_range(0, 'h5ff)), 24'($urandom)});
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule